// File: doc/BRIEF.md
# Serial-Strobed Board Control Register Slave

This block is the slave end of a board-management control link made of three serial wires (clock, data in, data out) and an active-low strobe. The master shifts bits in MSB first on rising serial-clock edges, in one unbroken stream with no chip select. It then commits the transaction with a single serial-clock pulse taken while the strobe is low. The data-in level on that committing edge selects the operation. A write stream is 32 data bits followed by 8 address bits. A read stream is only the 8 address bits. After a read commit, the slave returns the addressed 32-bit word MSB first, one bit per following serial-clock pulse.

The slave holds a small board register map: three read/write configuration words (operating mode, signal multiplexer, display link), a read-only switch bank, a read/write reset-control word and a read-only version word. Writing the reset-control word with bit 0 set drives a board reset pulse of fixed length. The word then clears itself. All serial pins are synchronized into the fast system clock. The serial-clock edges are detected in that clock domain.

Top module: `bdctl_serial_slave`

## Requirements
- R1: After reset, the mode, mux and display outputs are 0, `board_rst_o` is low and `ser_dout_o` is high.
- R2: Each rising serial-clock edge with the strobe high shifts `ser_din_i` into the frame, MSB first. Only the most recent 40 bits are kept: the last 8 are the address and the 32 before them are the write data.
- R3: A rising serial-clock edge with the strobe low commits the frame and shifts nothing. Data-in 1 means write and 0 means read. A second commit without new bits reuses the same frame.
- R4: Writes to address 0x00 (mode), 0x01 (mux) and 0x02 (display) store the data, drive it on `mode_o`, `mux_o` and `hdmi_o`, and read back unchanged.
- R5: A read commit puts bit 31 of the addressed word on `ser_dout_o`. The falling edge of the committing pulse does not advance it. Each later falling edge advances it by one bit. After the 32nd bit, `ser_dout_o` returns high and stays high.
- R6: A read of 0x08 returns the synchronized `dip_i` value, and a read of 0xFF returns `version_i`.
- R7: Writes to 0x08, 0xFF or any unmapped address change no output and no readable register.
- R8: A read of any unmapped address returns 0.
- R9: A write to 0x80 stores the word. When bit 0 is set, `board_rst_o` goes high for exactly RST_CYCLES system clocks, and the word reads 0 once the pulse ends. A word with bit 0 clear stays stored and gives no pulse.
- R10: With the default two synchronizer stages, an output that responds to a serial-clock edge changes on the third rising system-clock edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from master, idles low |
| ser_stb_n_i | input | 1 | Active-low commit strobe, idles high |
| ser_din_i | input | 1 | Serial data from master, idles low |
| ser_dout_o | output | 1 | Serial readback data, high when idle |
| dip_i | input | 32 | Board switch bank, asynchronous |
| version_i | input | 32 | Version word, static |
| mode_o | output | 32 | Mode configuration word |
| mux_o | output | 32 | Multiplexer configuration word |
| hdmi_o | output | 32 | Display-link configuration word |
| board_rst_o | output | 1 | Board reset pulse, active high |

## Verification
The bench drives full write streams and address-only read streams. Some write streams carry extra leading bits, which shows whether only the last 40 bits form the frame. A read commit issued straight after a write commit, with no new bits, tells a commit that shifts apart from one that does not. Writes to read-only and unmapped addresses, followed by readback, separate decoded stores from ignored ones. Reset-control writes with bit 0 clear and with bit 0 set separate a stored word from a triggered pulse. A behavioural model compares every output on every system clock, which fixes the three-clock pin-to-output latency and the point at which readback bits advance.

// File: rtl/bdctl_pkg.sv
package bdctl_pkg;
  localparam int DW      = 32;
  localparam int AW      = 8;
  localparam int FRAME_W = DW + AW;
  localparam int NUM_RW  = 3;

  typedef logic [DW-1:0] word_t;
  typedef logic [AW-1:0] addr_t;

  localparam addr_t A_MODE = 8'h00;
  localparam addr_t A_MUX  = 8'h01;
  localparam addr_t A_HDMI = 8'h02;
  localparam addr_t A_DIP  = 8'h08;
  localparam addr_t A_RST  = 8'h80;
  localparam addr_t A_VER  = 8'hFF;

  // address of the i-th plain read/write configuration word
  function automatic addr_t rw_addr(input int i);
    case (i)
      0:       return A_MODE;
      1:       return A_MUX;
      default: return A_HDMI;
    endcase
  endfunction
endpackage

// File: rtl/bdctl_sync.sv
module bdctl_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= {STAGES{RST_VAL}};
    end else begin
      st[0] <= d;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/bdctl_rx.sv
module bdctl_rx
  import bdctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  s_clk,
  input  logic  s_stb_n,
  input  logic  s_din,
  output logic  sclk_fall,
  output logic  cmd_wr,
  output logic  cmd_rd,
  output addr_t cmd_addr,
  output word_t cmd_data
);
  logic               clk_q;
  logic               sclk_rise;
  logic [FRAME_W-1:0] frame_q;

  assign sclk_rise = s_clk & ~clk_q;
  assign sclk_fall = ~s_clk & clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q   <= 1'b0;
      frame_q <= '0;
    end else begin
      clk_q <= s_clk;
      if (sclk_rise && s_stb_n) frame_q <= {frame_q[FRAME_W-2:0], s_din};
    end
  end

  // commit: strobe-qualified rising edge, data line carries the command
  assign cmd_wr   = sclk_rise & ~s_stb_n & s_din;
  assign cmd_rd   = sclk_rise & ~s_stb_n & ~s_din;
  assign cmd_addr = frame_q[AW-1:0];
  assign cmd_data = frame_q[FRAME_W-1:AW];
endmodule

// File: rtl/bdctl_regs.sv
module bdctl_regs
  import bdctl_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cmd_wr,
  input  addr_t cmd_addr,
  input  word_t cmd_data,
  input  word_t dip_s,
  input  word_t version_i,
  output word_t rd_word,
  output word_t mode_o,
  output word_t mux_o,
  output word_t hdmi_o,
  output logic  board_rst_o
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  word_t            rw_val [NUM_RW];
  word_t            rstw_q;
  logic [CNT_W-1:0] pulse_cnt;

  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    word_t q_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  q_r <= '0;
      else if (cmd_wr && cmd_addr == rw_addr(g))   q_r <= cmd_data;
    end
    assign rw_val[g] = q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstw_q    <= '0;
      pulse_cnt <= '0;
    end else if (cmd_wr && cmd_addr == A_RST) begin
      rstw_q <= cmd_data;
      if (cmd_data[0]) pulse_cnt <= CNT_W'(RST_CYCLES);
    end else if (pulse_cnt != '0) begin
      pulse_cnt <= pulse_cnt - 1'b1;
      if (pulse_cnt == CNT_W'(1)) rstw_q <= '0;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_RW; i++)
      if (cmd_addr == rw_addr(i)) rd_word = rw_val[i];
    if (cmd_addr == A_DIP) rd_word = dip_s;
    if (cmd_addr == A_VER) rd_word = version_i;
    if (cmd_addr == A_RST) rd_word = rstw_q;
  end

  assign mode_o      = rw_val[0];
  assign mux_o       = rw_val[1];
  assign hdmi_o      = rw_val[2];
  assign board_rst_o = (pulse_cnt != '0);
endmodule

// File: rtl/bdctl_tx.sv
module bdctl_tx
  import bdctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t load_word,
  input  logic  sclk_fall,
  output logic  ser_dout_o
);
  localparam int LEFT_W = $clog2(DW + 1);

  word_t             sh_q;
  logic [LEFT_W-1:0] left_q;
  logic              fresh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      left_q  <= '0;
      fresh_q <= 1'b0;
    end else if (load) begin
      sh_q    <= load_word;
      left_q  <= LEFT_W'(DW);
      fresh_q <= 1'b1;
    end else if (sclk_fall && left_q != '0) begin
      if (fresh_q) begin
        fresh_q <= 1'b0;  // falling edge of the committing pulse
      end else begin
        sh_q   <= {sh_q[DW-2:0], 1'b0};
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign ser_dout_o = (left_q != '0) ? sh_q[DW-1] : 1'b1;
endmodule

// File: rtl/bdctl_serial_slave.sv
module bdctl_serial_slave
  import bdctl_pkg::*;
#(
  parameter int RST_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk_i,
  input  logic          ser_stb_n_i,
  input  logic          ser_din_i,
  output logic          ser_dout_o,
  input  logic [DW-1:0] dip_i,
  input  logic [DW-1:0] version_i,
  output logic [DW-1:0] mode_o,
  output logic [DW-1:0] mux_o,
  output logic [DW-1:0] hdmi_o,
  output logic          board_rst_o
);
  logic [2:0] pins_s;
  word_t      dip_s;
  logic       sclk_fall;
  logic       cmd_wr;
  logic       cmd_rd;
  addr_t      cmd_addr;
  word_t      cmd_data;
  word_t      rd_word;

  bdctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_pin_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_clk_i, ser_stb_n_i, ser_din_i}), .q(pins_s)
  );

  bdctl_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dip_sync (
    .clk(clk), .rst_n(rst_n), .d(dip_i), .q(dip_s)
  );

  bdctl_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .s_clk(pins_s[2]), .s_stb_n(pins_s[1]), .s_din(pins_s[0]),
    .sclk_fall(sclk_fall), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  bdctl_regs #(.RST_CYCLES(RST_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .dip_s(dip_s), .version_i(version_i), .rd_word(rd_word),
    .mode_o(mode_o), .mux_o(mux_o), .hdmi_o(hdmi_o),
    .board_rst_o(board_rst_o)
  );

  bdctl_tx u_tx (
    .clk(clk), .rst_n(rst_n),
    .load(cmd_rd), .load_word(rd_word), .sclk_fall(sclk_fall),
    .ser_dout_o(ser_dout_o)
  );
endmodule

// File: rtl/bdctl_checker.sv
module bdctl_checker
  import bdctl_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input logic  clk,
  input logic  rst_n,
  input logic  wr_stb,
  input logic  rd_stb,
  input addr_t wr_addr,
  input word_t wr_data,
  input word_t rd_word,
  input logic  ser_dout_o,
  input word_t mode_o,
  input word_t mux_o,
  input word_t hdmi_o,
  input logic  board_rst_o
);
  int hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hi_cnt <= 0;
    else if (board_rst_o) hi_cnt <= hi_cnt + 1;
    else                  hi_cnt <= 0;
  end

  AST_RST_PULSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(board_rst_o) |-> $past(wr_stb && wr_addr == A_RST && wr_data[0])); // R9

  AST_RST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst_o |-> hi_cnt < RST_CYCLES); // R9

  AST_MODE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_o) |-> $past(wr_stb && wr_addr == A_MODE)); // R4

  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (wr_addr == A_DIP || wr_addr == A_VER)) |=>
      ($stable(mode_o) && $stable(mux_o) && $stable(hdmi_o) && !$rose(board_rst_o))); // R7

  AST_READ_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> ser_dout_o == $past(rd_word[DW-1])); // R5
endmodule

bind bdctl_serial_slave bdctl_checker #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(cmd_wr), .rd_stb(cmd_rd),
  .wr_addr(cmd_addr), .wr_data(cmd_data), .rd_word(rd_word),
  .ser_dout_o(ser_dout_o), .mode_o(mode_o), .mux_o(mux_o),
  .hdmi_o(hdmi_o), .board_rst_o(board_rst_o)
);

// File: tb/sim_bdctl_serial_slave.sv
module sim_bdctl_serial_slave;
  localparam int CLK_P = 10;
  localparam int H     = 4;       // system clocks per serial phase
  localparam int RST_C = 12;
  localparam int WD    = 100000;
  localparam logic [31:0] VER = 32'h0102_0304;
  localparam logic [31:0] DIP = 32'hA5C3_0F1E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk_i = 1'b0, ser_stb_n_i = 1'b1, ser_din_i = 1'b0;
  logic ser_dout_o, board_rst_o;
  logic [31:0] dip_i = '0, version_i = VER;
  logic [31:0] mode_o, mux_o, hdmi_o;

  int n_chk = 0, n_fail = 0;
  bit mon_on = 1'b0;

  // behavioural model state
  logic [31:0] m_rw [3];
  logic [31:0] m_rstw;
  int          m_cnt;
  bit          m_sh [$];
  bit          m_tx [$];
  bit          m_fresh;
  int          hi_run, last_len;

  always #(CLK_P/2) clk = ~clk;

  bdctl_serial_slave #(.RST_CYCLES(RST_C)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk_i), .ser_stb_n_i(ser_stb_n_i),
    .ser_din_i(ser_din_i), .ser_dout_o(ser_dout_o), .dip_i(dip_i),
    .version_i(version_i), .mode_o(mode_o), .mux_o(mux_o), .hdmi_o(hdmi_o),
    .board_rst_o(board_rst_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00:   return m_rw[0];
      8'h01:   return m_rw[1];
      8'h02:   return m_rw[2];
      8'h08:   return dip_i;
      8'h80:   return m_rstw;
      8'hFF:   return version_i;
      default: return '0;
    endcase
  endfunction

  task automatic model_rise();
    logic [39:0] fr;
    logic [31:0] w;
    if (ser_stb_n_i) begin
      m_sh.push_back(ser_din_i);
      if (m_sh.size() > 40) void'(m_sh.pop_front());
    end else begin
      fr = '0;
      foreach (m_sh[i]) fr = {fr[38:0], m_sh[i]};
      if (ser_din_i) begin
        case (fr[7:0])
          8'h00: m_rw[0] = fr[39:8];
          8'h01: m_rw[1] = fr[39:8];
          8'h02: m_rw[2] = fr[39:8];
          8'h80: begin m_rstw = fr[39:8]; if (fr[8]) m_cnt = RST_C; end
          default: ;
        endcase
      end else begin
        w = m_read(fr[7:0]);
        m_tx.delete();
        for (int i = 31; i >= 0; i--) m_tx.push_back(w[i]);
        m_fresh = 1'b1;
      end
    end
  endtask

  task automatic model_fall();
    if (m_tx.size() != 0) begin
      if (m_fresh) m_fresh = 1'b0;
      else void'(m_tx.pop_front());
    end
  endtask

  // every-clock comparison against the model (R10 latency is implied)
  always @(posedge clk) begin
    #(CLK_P/4);
    if (mon_on) begin
      chk("R4 R10 mode_o", mode_o, m_rw[0]);
      chk("R4 R10 mux_o", mux_o, m_rw[1]);
      chk("R4 R10 hdmi_o", hdmi_o, m_rw[2]);
      chk("R5 R10 ser_dout_o", {31'b0, ser_dout_o}, {31'b0, (m_tx.size() != 0) ? m_tx[0] : 1'b1});
      chk("R9 R10 board_rst_o", {31'b0, board_rst_o}, {31'b0, m_cnt != 0});
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) m_rstw = '0;
      end
      if (board_rst_o) hi_run++;
      else if (hi_run != 0) begin last_len = hi_run; hi_run = 0; end
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rise_edge();
    ser_clk_i = 1'b1; wait_n(2); model_rise(); wait_n(H-2);
  endtask

  task automatic fall_edge();
    ser_clk_i = 1'b0; wait_n(2); model_fall(); wait_n(H-2);
  endtask

  task automatic send_bit(logic b);
    ser_din_i = b; wait_n(H); rise_edge(); fall_edge();
  endtask

  task automatic send_addr(logic [7:0] a);
    for (int i = 7; i >= 0; i--) send_bit(a[i]);
  endtask

  task automatic commit(logic cmd);
    ser_din_i = cmd; ser_stb_n_i = 1'b0; wait_n(H);
    rise_edge(); fall_edge();
    ser_stb_n_i = 1'b1; ser_din_i = 1'b0; wait_n(H);
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    for (int i = 31; i >= 0; i--) send_bit(d[i]);
    send_addr(a);
    commit(1'b1);
  endtask

  task automatic read_bits(output logic [31:0] d);
    d = '0;
    for (int i = 0; i < 32; i++) begin
      rise_edge();
      d = {d[30:0], ser_dout_o};
      fall_edge();
    end
  endtask

  task automatic rd_expect(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    send_addr(a);
    commit(1'b0);
    read_bits(d);
    chk(tag, d, exp);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    m_rw[0] = '0; m_rw[1] = '0; m_rw[2] = '0; m_rstw = '0; m_cnt = 0;
    m_fresh = 1'b0; hi_run = 0; last_len = 0;
    wait_n(5);
    rst_n = 1'b1;
    mon_on = 1'b1;
    wait_n(2);

    // R1 reset state
    chk("R1 ser_dout_o idle", {31'b0, ser_dout_o}, 32'h1);
    chk("R1 board_rst_o idle", {31'b0, board_rst_o}, 32'h0);
    chk("R1 mode_o reset", mode_o, '0);
    rd_expect("R1 mode readback after reset", 8'h00, 32'h0);

    // R4 read/write words
    wr_reg(8'h00, 32'hDEAD_BEEF);
    wr_reg(8'h01, 32'h1234_5678);
    wr_reg(8'h02, 32'h0F0F_00FF);
    chk("R4 mode_o", mode_o, 32'hDEAD_BEEF);
    chk("R4 mux_o", mux_o, 32'h1234_5678);
    chk("R4 hdmi_o", hdmi_o, 32'h0F0F_00FF);
    rd_expect("R4 mode readback", 8'h00, 32'hDEAD_BEEF);
    rd_expect("R4 mux readback", 8'h01, 32'h1234_5678);
    rd_expect("R4 hdmi readback", 8'h02, 32'h0F0F_00FF);

    // R2 extra leading bits are pushed out of the frame
    for (int i = 0; i < 16; i++) send_bit(1'b1);
    wr_reg(8'h01, 32'hCAFE_0001);
    chk("R2 mux_o after long stream", mux_o, 32'hCAFE_0001);

    // R3 commit does not shift: a read commit right after a write reuses the frame
    wr_reg(8'h02, 32'h55AA_33CC);
    commit(1'b0);
    read_bits(d);
    chk("R3 read reuses frame", d, 32'h55AA_33CC);
    chk("R3 read commit leaves hdmi_o", hdmi_o, 32'h55AA_33CC);

    // R5 readback order and idle level afterwards
    wr_reg(8'h00, 32'h8000_0001);
    rd_expect("R5 msb/lsb order", 8'h00, 32'h8000_0001);
    chk("R5 dout high after 32 bits", {31'b0, ser_dout_o}, 32'h1);
    rise_edge(); fall_edge();
    chk("R5 dout stays high", {31'b0, ser_dout_o}, 32'h1);

    // R6 switch bank and version
    dip_i = DIP;
    wait_n(8);
    rd_expect("R6 dip readback", 8'h08, DIP);
    rd_expect("R6 version readback", 8'hFF, VER);

    // R7 ignored writes, R8 unmapped reads
    wr_reg(8'h08, 32'hFFFF_FFFF);
    wr_reg(8'hFF, 32'h0000_0000);
    wr_reg(8'h03, 32'h1111_1111);
    chk("R7 mode_o unchanged", mode_o, 32'h8000_0001);
    chk("R7 mux_o unchanged", mux_o, 32'hCAFE_0001);
    chk("R7 board_rst_o low", {31'b0, board_rst_o}, 32'h0);
    rd_expect("R7 dip not overwritten", 8'h08, DIP);
    rd_expect("R7 version not overwritten", 8'hFF, VER);
    rd_expect("R8 unmapped 0x03", 8'h03, 32'h0);
    rd_expect("R8 unmapped 0x7F", 8'h7F, 32'h0);

    // R9 reset control
    wr_reg(8'h80, 32'h0000_0002);
    chk("R9 no pulse for bit0 clear", {31'b0, board_rst_o}, 32'h0);
    rd_expect("R9 stored word", 8'h80, 32'h0000_0002);
    wr_reg(8'h80, 32'h0000_0001);
    wait_n(RST_C + 4);
    chk("R9 pulse width", last_len, RST_C);
    chk("R9 pulse ended", {31'b0, board_rst_o}, 32'h0);
    rd_expect("R9 word self-cleared", 8'h80, 32'h0);

    wait_n(4);
    summary();
    $finish;
  end
endmodule